// File: doc/BRIEF.md
# ADC Control Register Bank with Atomic Bit Operations

This block holds the control state of an analog-to-digital converter peripheral and exposes it on a simple synchronous bus (byte address, write strobe, read strobe, write data, registered read data). Six 32-bit registers live in the bank: three general control words, a channel selector, a scan-input mask and a pin-mode word. Each register owns one 16-byte slot. Inside that slot, address bits [3:2] pick how a write is applied: plain overwrite, clear-by-mask, set-by-mask or toggle-by-mask. Software can therefore change single bits without a read-modify-write sequence.

The region that follows the registers is a block of sixteen result slots. It answers reads with zero and takes no writes; conversion results are captured elsewhere. Addresses beyond the end of the window read as zero and are ignored. The one hole inside the window (slot 0x030) reports an access error. The block has no sequencing state: every access completes in one cycle, and read data and the error flag appear one cycle later.

Top module: `adcctl_regbank`

## Requirements
- R1: While reset is held, and right after it is released, all six registers read zero.
- R2: A write with address bits [3:2] = 00 replaces the whole register with the write data. A read at any byte offset 0x0 to 0xF inside the slot returns the full register value.
- R3: A write with address bits [3:2] = 01 clears each register bit whose write-data bit is 1 and leaves the other bits unchanged.
- R4: A write with address bits [3:2] = 10 sets each register bit whose write-data bit is 1 and leaves the other bits unchanged.
- R5: A write with address bits [3:2] = 11 inverts each register bit whose write-data bit is 1 and leaves the other bits unchanged.
- R6: The slot bases are: control A at 0x000, control B at 0x010, control C at 0x020, channel select at 0x040, scan mask at 0x050 and pin mode at 0x060. A write to one slot changes no other register.
- R7: Offsets 0x070 to 0x16F (sixteen result slots) read as zero. A write to them changes no register and raises no error.
- R8: Offsets 0x170 and above read as zero. A write there changes no register. Neither kind of access raises the error flag.
- R9: A read or write at offset 0x030 to 0x03F makes the error flag high for exactly the one cycle after the access. Such a read returns zero and such a write changes no register.
- R10: Read data appears in the cycle after the read strobe. In a cycle that follows no read strobe, the read data is zero.
- R11: If a read and a write to the same register happen in the same cycle, the read returns the value from before the write. The new value is visible to the next read.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_addr | input | 12 | Byte offset into the register window |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 32 | Write data, or the bit mask for the clear, set and toggle operations |
| bus_rdata | output | 32 | Read data, one cycle after bus_rd |
| bus_err | output | 1 | One-cycle pulse after an access to the undefined slot |

## Verification
The only internal state is the six register words, so a wrong bit shows on the first read of the affected slot, one cycle after its strobe. To catch a mis-decoded operation code or slot, each atomic operation is applied to a known value and read back at a different offset in the slot. All six slots are also read back after other slots are written. Accesses to the result region, to the hole and past the end of the window are each followed by register reads, which show any stray write within two cycles. The error flag is sampled in the cycle after every access.

// File: rtl/adcctl_pkg.sv
package adcctl_pkg;

    localparam int NUM_CTRL          = 6;
    localparam int SLOT_SHIFT        = 4;
    localparam int WINDOW_BYTES      = 'h170;
    localparam int RESULT_FIRST_SLOT = 7;
    localparam int RESULT_SLOTS      = 16;

    typedef enum logic [1:0] {
        OP_ASSIGN = 2'b00,
        OP_CLEAR  = 2'b01,
        OP_SET    = 2'b10,
        OP_TOGGLE = 2'b11
    } wop_e;

    // Slot index of control register idx; slot 3 is left as a hole.
    function automatic int ctrl_slot(int idx);
        return (idx < 3) ? idx : idx + 1;
    endfunction

endpackage

// File: rtl/adcctl_decode.sv
module adcctl_decode
    import adcctl_pkg::*;
#(
    parameter int ADDR_W = 12
) (
    input  logic [ADDR_W-1:0]   addr,
    output logic [NUM_CTRL-1:0] ctrl_hit,
    output logic                result_hit,
    output logic                undef_hit
);

    localparam int SLOT_W = ADDR_W - SLOT_SHIFT;

    logic [SLOT_W-1:0] slot;
    logic              in_window;

    assign slot      = addr[ADDR_W-1:SLOT_SHIFT];
    assign in_window = (addr < ADDR_W'(WINDOW_BYTES));

    for (genvar gi = 0; gi < NUM_CTRL; gi++) begin : g_hit
        localparam int SLOT_IDX = ctrl_slot(gi);
        assign ctrl_hit[gi] = in_window && (slot == SLOT_W'(SLOT_IDX));
    end

    assign result_hit = in_window
                     && (slot >= SLOT_W'(RESULT_FIRST_SLOT))
                     && (slot <  SLOT_W'(RESULT_FIRST_SLOT + RESULT_SLOTS));

    assign undef_hit  = in_window && !(|ctrl_hit) && !result_hit;

endmodule

// File: rtl/adcctl_ctrlreg.sv
module adcctl_ctrlreg
    import adcctl_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  wop_e              op,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] q
);

    logic [DATA_W-1:0] nxt;

    always_comb begin
        unique case (op)
            OP_ASSIGN: nxt = wdata;
            OP_CLEAR:  nxt = q & ~wdata;
            OP_SET:    nxt = q | wdata;
            OP_TOGGLE: nxt = q ^ wdata;
            default:   nxt = q;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else if (we) begin
            q <= nxt;
        end
    end

endmodule

// File: rtl/adcctl_regbank.sv
module adcctl_regbank
    import adcctl_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              bus_err
);

    logic [NUM_CTRL-1:0]             ctrl_hit;
    logic                            result_hit;
    logic                            undef_hit;
    logic [NUM_CTRL-1:0][DATA_W-1:0] regs_q;
    logic [DATA_W-1:0]               rd_mux;
    wop_e                            wop;

    assign wop = wop_e'(bus_addr[3:2]);

    adcctl_decode #(.ADDR_W(ADDR_W)) u_dec (
        .addr       (bus_addr),
        .ctrl_hit   (ctrl_hit),
        .result_hit (result_hit),
        .undef_hit  (undef_hit)
    );

    for (genvar gi = 0; gi < NUM_CTRL; gi++) begin : g_reg
        adcctl_ctrlreg #(.DATA_W(DATA_W)) u_reg (
            .clk   (clk),
            .rst_n (rst_n),
            .we    (bus_wr && ctrl_hit[gi]),
            .op    (wop),
            .wdata (bus_wdata),
            .q     (regs_q[gi])
        );
    end

    // Result slots, the hole and out-of-window offsets all fall to zero.
    always_comb begin
        rd_mux = '0;
        for (int i = 0; i < NUM_CTRL; i++) begin
            if (ctrl_hit[i]) rd_mux = rd_mux | regs_q[i];
        end
        if (result_hit) rd_mux = '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bus_rdata <= '0;
            bus_err   <= 1'b0;
        end else begin
            bus_rdata <= bus_rd ? rd_mux : '0;
            bus_err   <= (bus_rd || bus_wr) && undef_hit;
        end
    end

endmodule

// File: rtl/adcctl_regbank_chk.sv
module adcctl_regbank_chk
    import adcctl_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter int DATA_W = 32
) (
    input logic                            clk,
    input logic                            rst_n,
    input logic [ADDR_W-1:0]               bus_addr,
    input logic                            bus_wr,
    input logic                            bus_rd,
    input logic [DATA_W-1:0]               bus_rdata,
    input logic                            bus_err,
    input logic [NUM_CTRL-1:0][DATA_W-1:0] regs_q
);

    logic in_win;
    logic at_hole;
    logic at_result;

    assign in_win    = bus_addr < ADDR_W'(WINDOW_BYTES);
    assign at_hole   = bus_addr[ADDR_W-1:4] == (ADDR_W-4)'(3);
    assign at_result = in_win && (bus_addr >= ADDR_W'('h070));

    AST_RESET_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (regs_q == '0)); // R1

    AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && at_result) |=> $stable(regs_q)); // R7

    AST_OOW_WRITE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && !in_win) |=> $stable(regs_q)); // R8

    AST_OOW_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && !in_win) |=> (bus_rdata == '0 && !bus_err)); // R8

    AST_HOLE_ERR: assert property (@(posedge clk) disable iff (!rst_n)
        ((bus_rd || bus_wr) && at_hole) |=> (bus_err && bus_rdata == '0)); // R9

    AST_ERR_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        bus_err |-> $past(bus_rd || bus_wr)); // R9

    AST_IDLE_RDATA_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rd |=> (bus_rdata == '0)); // R10

endmodule

bind adcctl_regbank adcctl_regbank_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_wr    (bus_wr),
    .bus_rd    (bus_rd),
    .bus_rdata (bus_rdata),
    .bus_err   (bus_err),
    .regs_q    (regs_q)
);

// File: tb/sim_adcctl_regbank.sv
`timescale 1ns/1ps
module sim_adcctl_regbank;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [11:0] bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        bus_err;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #2.5 clk = ~clk;

    adcctl_regbank u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_addr  (bus_addr),
        .bus_wr    (bus_wr),
        .bus_rd    (bus_rd),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .bus_err   (bus_err)
    );

    // {req[3:0], is_write, addr[11:0], data_or_expected[31:0]}
    localparam int NV = 22;
    localparam logic [48:0] VEC [NV] = '{
        {4'd2,  1'b1, 12'h000, 32'hA5A5_0000},  // R2 assign
        {4'd2,  1'b0, 12'h000, 32'hA5A5_0000},
        {4'd2,  1'b0, 12'h00F, 32'hA5A5_0000},  // R2 any offset in slot
        {4'd3,  1'b1, 12'h004, 32'h0500_0000},  // R3 clear mask
        {4'd3,  1'b0, 12'h008, 32'hA0A5_0000},
        {4'd4,  1'b1, 12'h008, 32'h0000_00FF},  // R4 set mask
        {4'd4,  1'b0, 12'h004, 32'hA0A5_00FF},
        {4'd5,  1'b1, 12'h00C, 32'hFFFF_0000},  // R5 toggle mask
        {4'd5,  1'b0, 12'h000, 32'h5F5A_00FF},
        {4'd6,  1'b1, 12'h010, 32'h1111_1111},  // R6 slot bases
        {4'd6,  1'b1, 12'h020, 32'h2222_2222},
        {4'd6,  1'b1, 12'h040, 32'h4444_4444},
        {4'd6,  1'b1, 12'h050, 32'h5555_5555},
        {4'd6,  1'b1, 12'h060, 32'h6666_6660},
        {4'd4,  1'b1, 12'h068, 32'h0000_0001},  // R4 on pin mode
        {4'd6,  1'b0, 12'h000, 32'h5F5A_00FF},
        {4'd6,  1'b0, 12'h014, 32'h1111_1111},
        {4'd6,  1'b0, 12'h028, 32'h2222_2222},
        {4'd6,  1'b0, 12'h04C, 32'h4444_4444},
        {4'd6,  1'b0, 12'h050, 32'h5555_5555},
        {4'd4,  1'b0, 12'h064, 32'h6666_6661},
        {4'd5,  1'b0, 12'h004, 32'h5F5A_00FF}
    };

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
        end
    endtask

    function automatic logic hole(input logic [11:0] a);
        return (a >= 12'h030) && (a <= 12'h03F);
    endfunction

    // Drive at negedge, capture on posedge, sample at the following negedge.
    task automatic do_write(input logic [11:0] a, input logic [31:0] d);
        bus_addr  = a;
        bus_wdata = d;
        bus_wr    = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
        check($sformatf("R9 err after write %03h", a), {31'd0, bus_err}, {31'd0, hole(a)});
    endtask

    task automatic do_read(input logic [11:0] a, input logic [31:0] exp, input string tag);
        bus_addr = a;
        bus_rd   = 1'b1;
        @(negedge clk);
        bus_rd = 1'b0;
        check($sformatf("%s read %03h", tag, a), bus_rdata, exp);
        check($sformatf("R9 err after read %03h", a), {31'd0, bus_err}, {31'd0, hole(a)});
    endtask

    task automatic read_all_zero(input string tag);
        do_read(12'h000, 32'h0, tag);
        do_read(12'h010, 32'h0, tag);
        do_read(12'h020, 32'h0, tag);
        do_read(12'h040, 32'h0, tag);
        do_read(12'h050, 32'h0, tag);
        do_read(12'h060, 32'h0, tag);
    endtask

    initial begin
        #(5.0 * 150000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R1 rdata in reset", bus_rdata, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);
        read_all_zero("R1");

        for (int i = 0; i < NV; i++) begin
            if (VEC[i][44]) begin
                do_write(VEC[i][43:32], VEC[i][31:0]);
            end else begin
                do_read(VEC[i][43:32], VEC[i][31:0], $sformatf("R%0d table", VEC[i][48:45]));
            end
        end

        // R7: result region
        do_write(12'h070, 32'hDEAD_BEEF);
        do_write(12'h16C, 32'hFFFF_FFFF);
        do_read(12'h070, 32'h0, "R7");
        do_read(12'h0F8, 32'h0, "R7");
        do_read(12'h16C, 32'h0, "R7");
        do_read(12'h000, 32'h5F5A_00FF, "R7 no side effect");
        do_read(12'h060, 32'h6666_6661, "R7 no side effect");

        // R8: beyond the window
        do_write(12'h170, 32'h1234_5678);
        do_write(12'h800, 32'h1234_5678);
        do_read(12'h170, 32'h0, "R8");
        do_read(12'hFFC, 32'h0, "R8");
        do_read(12'h010, 32'h1111_1111, "R8 no side effect");

        // R9: the hole; error lasts exactly one cycle
        do_write(12'h030, 32'hFFFF_FFFF);
        @(negedge clk);
        check("R9 err drops after one cycle", {31'd0, bus_err}, 32'h0);
        do_read(12'h034, 32'h0, "R9");
        do_read(12'h020, 32'h2222_2222, "R9 no side effect");
        do_read(12'h040, 32'h4444_4444, "R9 no side effect");

        // R10: idle cycle after a read returns zero
        do_read(12'h050, 32'h5555_5555, "R10");
        @(negedge clk);
        check("R10 idle rdata", bus_rdata, 32'h0);

        // R11: read and write to the same register in one cycle
        bus_addr  = 12'h018;   // set op on control B
        bus_wdata = 32'h0000_00F0;
        bus_wr    = 1'b1;
        bus_rd    = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
        bus_rd = 1'b0;
        check("R11 old value", bus_rdata, 32'h1111_1111);
        do_read(12'h010, 32'h1111_11F1, "R11 new value");

        // R1: reset in mid-run
        rst_n = 1'b0;
        @(negedge clk);
        check("R1 rdata in reset", bus_rdata, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);
        read_all_zero("R1 after re-reset");

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule